// File: doc/BRIEF.md
# Counter-Addressed Sine Waveform Generator

This block produces a sine wave as a stream of unsigned samples for an external digital-to-analogue converter. A table built at elaboration time holds one full cycle. A wrapping address counter walks through that table and moves one step on every clock where the sample enable is high. No sine arithmetic is done at run time. Each output sample comes from one registered table read.

The samples are offset binary. The midpoint of the code range stands for zero, and the full code range is the peak-to-peak swing, so the byte can go straight to a converter. With the enable held high, one period takes one clock per table entry. The output frequency is therefore the clock rate divided by the table depth, which is 256 at the default sizes. A one-clock strobe marks the clock in which the sample taken from address 0 appears, so downstream logic can lock to the phase.

Top module: `sine_wave_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `sample_o` becomes 128 (midscale) and `period_start_o` becomes 0 at that edge. The address returns to 0, so the first enabled clock after reset outputs the entry at index 0.
- R2: At each rising edge where `sample_en` is high, `sample_o` takes the table entry at the current address, and the address then increases by one.
- R3: The address wraps from 255 to 0. The enabled clock after the one that output index 255 outputs index 0 again.
- R4: At a rising edge where `sample_en` is low, `sample_o` and the address keep their values, and `period_start_o` is 0.
- R5: The table entry at index i is floor(128 + 127.5·sin(2π·i/256)). Index 0 therefore holds 128, index 64 holds 255 and index 192 holds 0.
- R6: `period_start_o` is 1 for exactly the clock that follows an enabled edge which read index 0, and is 0 in every other clock. Whenever it is 1, `sample_o` is 128.
- R7: With `sample_en` held high, two rising edges of `period_start_o` are exactly 256 clocks apart. The output frequency is the clock rate divided by 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Advance enable: one table step per clock where it is high |
| sample_o | output | 8 | Registered offset-binary sine sample |
| period_start_o | output | 1 | One-clock strobe while the index-0 sample is on the output |

## Verification
The bench builds the block with its default sizes: an 8-bit address and 8-bit samples. With these sizes a full period takes only 256 enabled clocks, so a long enabled run walks every table entry several times. That run crosses the 255-to-0 wrap repeatedly and allows the exact spacing between strobes to be measured. A random enable pattern and a reset applied in mid-period then exercise the stall and restart behaviour at arbitrary phases.

// File: rtl/sinegen_pkg.sv
// sinegen_pkg: shared constants and the elaboration-time sine table function.
// Assumes the function is only called with constant arguments, so the real
// arithmetic is folded away before any hardware is built.
package sinegen_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // One offset-binary sine entry: floor(mid + half_span * sin(2*pi*idx/depth)).
    function automatic int sine_entry(input int idx, input int addr_w, input int data_w);
        real full_code;
        real half_span;
        real mid_code;
        real angle;
        real value;
        int  code;
        full_code = real'((1 << data_w) - 1);
        half_span = full_code / 2.0;
        mid_code  = real'(1 << (data_w - 1));
        angle     = TWO_PI * real'(idx) / real'(1 << addr_w);
        value     = $floor(mid_code + half_span * $sin(angle));
        code      = $rtoi(value);
        if (code < 0) begin
            code = 0;
        end
        if (code > (1 << data_w) - 1) begin
            code = (1 << data_w) - 1;
        end
        return code;
    endfunction

endpackage

// File: rtl/sinegen_addr_ctr.sv
// sinegen_addr_ctr: wrapping table address counter.
// Advances by one on each enabled clock and wraps naturally at 2**ADDR_W.
// Assumes a synchronous active-low reset that returns the address to zero.
module sinegen_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_origin_o
);

    logic [ADDR_W-1:0] addr_q;

    // Step the address on enable; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step_en) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Flag the first entry of the table for the strobe stage.
    always_comb begin
        at_origin_o = (addr_q == '0);
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/sinegen_rom.sv
// sinegen_rom: full-cycle sine table with a registered read port.
// The table is computed at elaboration time from sinegen_pkg::sine_entry.
// The output register loads only on enabled clocks and resets to midscale.
module sinegen_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1 << (DATA_W - 1));

    logic [DATA_W-1:0] table_w [DEPTH];
    logic [DATA_W-1:0] data_q;

    // Each table entry is a constant computed at elaboration time.
    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign table_w[g] = DATA_W'(sinegen_pkg::sine_entry(g, ADDR_W, DATA_W));
    end

    // Register the addressed entry on enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= MIDSCALE;
        end else if (rd_en) begin
            data_q <= table_w[addr_i];
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/sinegen_strobe.sv
// sinegen_strobe: period-start marker aligned with the registered sample.
// It is high for one clock after an enabled read of index zero.
// Assumes at_origin_i describes the address used by the same enabled read.
module sinegen_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic at_origin_i,
    output logic strobe_o
);

    logic strobe_q;

    // Raise the strobe only for an enabled read of index zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= step_en & at_origin_i;
        end
    end

    assign strobe_o = strobe_q;

endmodule

// File: rtl/sine_wave_gen.sv
// sine_wave_gen: counter-addressed sine waveform generator.
// A wrapping counter addresses a full-cycle table. Samples and the
// period-start strobe are registered and move forward only on sample_en.
// Assumes clk is the sample clock and rst_n is synchronous, active low.
module sine_wave_gen #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    output logic [DATA_W-1:0] sample_o,
    output logic              period_start_o
);

    logic [ADDR_W-1:0] addr_q;
    logic              at_origin;

    sinegen_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (sample_en),
        .addr_o      (addr_q),
        .at_origin_o (at_origin)
    );

    sinegen_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rom_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (sample_en),
        .addr_i (addr_q),
        .data_o (sample_o)
    );

    sinegen_strobe strobe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (sample_en),
        .at_origin_i (at_origin),
        .strobe_o    (period_start_o)
    );

endmodule

// File: rtl/sine_wave_gen_chk.sv
// sine_wave_gen_chk: property checker for sine_wave_gen, attached by bind.
// Observes the ports and the internal table address of the top module.
module sine_wave_gen_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DATA_W-1:0] sample,
    input logic              strobe,
    input logic [ADDR_W-1:0] addr
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    // R1: reset puts the outputs at midscale/idle and the address at zero.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (sample == MID) && !strobe && (addr == '0));

    // R2: an enabled clock advances the address by one.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));

    // R3: the address wraps from the last index back to zero.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && addr == LAST) |=> addr == '0);

    // R4: a disabled clock holds the sample and the address, and the strobe stays low.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sample) && $stable(addr) && !strobe);

    // R6: the strobe lasts one clock and comes with the midscale sample.
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    p_strobe_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> sample == MID);

endmodule

bind sine_wave_gen sine_wave_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (sample_en),
    .sample (sample_o),
    .strobe (period_start_o),
    .addr   (addr_q)
);

// File: tb/sine_wave_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for sine_wave_gen: directed runs mixed with seeded random enables,
// compared against a reference model written from the requirements.
module sine_wave_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic [7:0] sample_o;
    logic       period_start_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state.
    int  m_addr = 0;
    int  exp_sample = 128;
    bit  exp_strobe = 1'b0;
    int  last_idx = -1;
    bit  seen_wrap = 1'b0;
    string tag = "R1";

    // Strobe spacing measurement.
    bit  spacing_on = 1'b0;
    int  since_strobe = -1;

    sine_wave_gen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_en      (sample_en),
        .sample_o       (sample_o),
        .period_start_o (period_start_o)
    );

    always #2.5 clk = ~clk;

    function automatic int ref_sine(input int i);
        real a;
        a = 6.283185307179586 * real'(i) / 256.0;
        return $rtoi($floor(128.0 + 127.5 * $sin(a)));
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one clock with the given inputs, update the model, then compare at the falling edge.
    task automatic step(input bit rst_v, input bit en_v);
        rst_n = rst_v;
        sample_en = en_v;
        @(posedge clk);
        if (!rst_v) begin
            m_addr = 0;
            exp_sample = 128;
            exp_strobe = 1'b0;
            seen_wrap = 1'b0;
            tag = "R1";
        end else if (en_v) begin
            exp_sample = ref_sine(m_addr);
            exp_strobe = (m_addr == 0);
            if (m_addr == 0 && last_idx == 255) begin
                tag = "R3";
                seen_wrap = 1'b1;
            end else if (m_addr == 0 || m_addr == 64 || m_addr == 192) begin
                tag = "R5";
            end else begin
                tag = "R2";
            end
            last_idx = m_addr;
            m_addr = (m_addr + 1) % 256;
        end else begin
            exp_strobe = 1'b0;
            tag = "R4";
        end
        @(negedge clk);
        check(tag, int'(sample_o), exp_sample, "sample_o");
        check((tag == "R1") ? "R1" : "R6", int'(period_start_o), int'(exp_strobe), "period_start_o");
        if (!rst_v) begin
            last_idx = -1;
        end
        if (spacing_on) begin
            if (period_start_o) begin
                if (since_strobe >= 0) begin
                    check("R7", since_strobe + 1, 256, "strobe spacing");
                end
                since_strobe = 0;
            end else if (since_strobe >= 0) begin
                since_strobe++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5A17_C0DE));
        @(negedge clk);
        // Reset state.
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // A disabled clock after reset changes nothing.
        step(1'b1, 1'b0);
        // Continuous enable over several periods: every entry, the wraps, the spacing.
        spacing_on = 1'b1;
        for (int i = 0; i < 900; i++) begin
            step(1'b1, 1'b1);
        end
        spacing_on = 1'b0;
        check("R3", int'(seen_wrap), 1, "wrap observed");
        // Random enables stall the stream at arbitrary phases.
        for (int i = 0; i < 2000; i++) begin
            step(1'b1, bit'($urandom_range(0, 3) != 0));
        end
        // Reset in mid-period, then restart from index 0.
        step(1'b0, 1'b1);
        for (int i = 0; i < 70; i++) begin
            step(1'b1, 1'b1);
        end
        // Long stall holding a non-midscale sample.
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0);
        end
        for (int i = 0; i < 300; i++) begin
            step(1'b1, bit'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule